// File: doc/BRIEF.md
# Serial Converter Interface Slave

This block models the digital face of an eight-input sampling converter, for use in emulation and verification setups. A host clocks a full-duplex three-wire serial link. During each frame it shifts in an eight-bit setup word that chooses the input channel, the input range and the power-down requests for the next conversion. In the same frame it shifts out the result of the previous conversion. A rising edge on the start pin begins a conversion, which uses the most recently captured setup word. A down-counter of programmable length stands in for the analog core. When the counter runs out, the block takes a sample from a valid/ready stream input and loads it into the output shifter.

All pins are sampled by the block clock, and edges are detected against the previous sample. Upstream logic must therefore supply pins that are already synchronous to the clock. The sample stream is the only place with back-pressure. The block raises `samp_ready` only once its conversion time has elapsed, and it holds `samp_ready` high until the producer asserts `samp_valid`. A sample transfers on the clock edge where both are high, and the conversion ends on that same edge. The producer may hold `samp_valid` high early. `samp_data` is ignored on every cycle without a transfer.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, `busy_n` is 1, `samp_ready` is 0, and `sdo` is 0. The decoded outputs show setup word 0x00: `pos_ch`=0, `neg_ch`=1, `neg_is_com`=0, `uni`=0, `gain`=0.
- R2: The setup word is taken from `sdi` on the first eight rising `sck` edges of a frame, first bit first. Bit order is: single-ended flag, odd/sign, select1, select0, unipolar, gain, nap, sleep. Further rising edges in the frame are ignored. A frame of fewer than eight edges leaves the pending word unchanged.
- R3: The decoded outputs change only on an accepted rising `convst` edge, one cycle after it is seen. They then hold until the next accepted edge.
- R4: With the single-ended flag at 1, `pos_ch` = {select1, select0, odd} and `neg_is_com` = 1. With the flag at 0, `pos_ch` = {select1, select0, odd}, `neg_ch` = {select1, select0, not odd} and `neg_is_com` = 0.
- R5: `busy_n` goes low the cycle after a rising `convst` edge. If `samp_valid` is already high, it stays low for exactly `CONV_CYCLES` cycles.
- R6: `samp_ready` is high only while busy, from the cycle the conversion time runs out until a transfer. Each cycle of `samp_valid` low after that extends the busy time by one cycle.
- R7: A rising `convst` edge while busy is ignored. This includes an edge in the very cycle the conversion completes. The conversion is neither restarted nor extended, and the decoded outputs keep their values.
- R8: After completion `sdo` shows the result MSB. Each falling `sck` edge advances it by one bit, MSB first, over a 16-bit word.
- R9: The sample is `RES_BITS` wide. The 16-bit result carries it in its upper bits, with the 16-`RES_BITS` trailing bits forced to 0.
- R10: Completing a conversion restarts the frame bit count. The next rising `sck` edge is always taken as the first setup bit.
- R11: `sdo_oe` is the inverse of `rd`. With `rd` tied low the output is always driven. With `rd` tied to `convst` the output is off during conversion and on again once both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convst | input | 1 | Conversion start; rising edge starts |
| rd | input | 1 | Read enable, active low |
| sck | input | 1 | Serial shift clock, sampled |
| sdi | input | 1 | Serial setup data in |
| samp_data | input | RES_BITS | Sample from the stand-in analog core |
| samp_valid | input | 1 | Sample valid |
| samp_ready | output | 1 | Block ready to take the sample |
| sdo | output | 1 | Serial result data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| busy_n | output | 1 | Low while converting |
| pos_ch | output | 3 | Positive input channel |
| neg_ch | output | 3 | Negative input channel (differential) |
| neg_is_com | output | 1 | Negative input is the common pin |
| uni | output | 1 | Unipolar range select |
| gain | output | 1 | Gain/range select |
| pd_req | output | 2 | Power-down request bits {nap, sleep} |

## Verification
The main overlap is between the completion of a conversion and a new rising `convst` edge in the same clock cycle. The bench provokes it by holding `samp_valid` low until `samp_ready` is seen. It then drops `convst` and raises `samp_valid` and `convst` together on one falling clock edge. The result is judged correct only if `busy_n` rises on the next cycle and stays high, with the decoded outputs unchanged, which shows the edge was not taken as a restart. A second overlap occurs when a completion meets a frame left partway through. Here the bench checks that the next full frame is captured from its first bit.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  localparam int CFG_W = 8;
  localparam int CH_W  = 3;

  // Setup word, first shifted bit in the MSB position.
  typedef struct packed {
    logic            single;
    logic            odd;
    logic [1:0]      sel;
    logic            uni;
    logic            gain;
    logic            nap;
    logic            sleep;
  } setup_t;

  typedef struct packed {
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
    logic            com;
  } route_t;

  function automatic route_t route_of(setup_t s);
    route_t r;
    r.pos = {s.sel, s.odd};
    if (s.single) begin
      r.neg = '0;
      r.com = 1'b1;
    end else begin
      r.neg = {s.sel, ~s.odd};
      r.com = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/setup_capture.sv
module setup_capture #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sdi,
  input  logic              frame_restart,
  output logic [WORD_W-1:0] pend_word
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [CW-1:0]     bit_cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      pend_word <= '0;
    end else if (frame_restart) begin
      bit_cnt <= '0;
    end else if (sck_rise && (bit_cnt != CW'(WORD_W))) begin
      shreg   <= {shreg[WORD_W-2:0], sdi};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CW'(WORD_W - 1))
        pend_word <= {shreg[WORD_W-2:0], sdi};
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic samp_valid,
  output logic busy,
  output logic samp_ready,
  output logic done
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= TW'(CONV_CYCLES - 1);
      end
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else if (samp_valid) begin
      busy <= 1'b0;
    end
  end

  assign samp_ready = busy && (remain == '0);
  assign done       = samp_ready && samp_valid;
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int RES_BITS = 14,
  parameter int OUT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RES_BITS-1:0] load_data,
  input  logic                sck_fall,
  output logic                sdo,
  output logic [OUT_W-1:0]    word
);
  localparam int PAD = OUT_W - RES_BITS;

  logic [OUT_W-1:0] padded;

  generate
    if (PAD > 0) begin : g_pad
      assign padded = {load_data, {PAD{1'b0}}};
    end else begin : g_full
      assign padded = load_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      word <= '0;
    else if (load)
      word <= padded;
    else if (sck_fall)
      word <= {word[OUT_W-2:0], 1'b0};
  end

  assign sdo = word[OUT_W-1];
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_if_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int OUT_W       = 16,
  parameter int CONV_CYCLES = 400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                convst,
  input  logic                rd,
  input  logic                sck,
  input  logic                sdi,
  input  logic [RES_BITS-1:0] samp_data,
  input  logic                samp_valid,
  output logic                samp_ready,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                busy_n,
  output logic [CH_W-1:0]     pos_ch,
  output logic [CH_W-1:0]     neg_ch,
  output logic                neg_is_com,
  output logic                uni,
  output logic                gain,
  output logic [1:0]          pd_req
);
  logic       sck_q, convst_q;
  logic       sck_rise, sck_fall, convst_rise;
  logic       busy, done, start_ok;
  logic [CFG_W-1:0] pend_word;
  setup_t     active;
  route_t     route;
  logic [OUT_W-1:0] res_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      convst_q <= 1'b0;
    end else begin
      sck_q    <= sck;
      convst_q <= convst;
    end
  end

  assign sck_rise    = sck & ~sck_q;
  assign sck_fall    = ~sck & sck_q;
  assign convst_rise = convst & ~convst_q;
  assign start_ok    = convst_rise & ~busy;

  setup_capture #(.WORD_W(CFG_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_rise      (sck_rise),
    .sdi           (sdi),
    .frame_restart (done),
    .pend_word     (pend_word)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (convst_rise),
    .samp_valid (samp_valid),
    .busy       (busy),
    .samp_ready (samp_ready),
    .done       (done)
  );

  result_shifter #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .load_data (samp_data),
    .sck_fall  (sck_fall),
    .sdo       (sdo),
    .word      (res_word)
  );

  // Setup in force for the conversion: swapped in only on an accepted start.
  always_ff @(posedge clk) begin
    if (!rst_n)
      active <= '0;
    else if (start_ok)
      active <= setup_t'(pend_word);
  end

  assign route      = route_of(active);
  assign pos_ch     = route.pos;
  assign neg_ch     = route.neg;
  assign neg_is_com = route.com;
  assign uni        = active.uni;
  assign gain       = active.gain;
  assign pd_req     = {active.nap, active.sleep};
  assign busy_n     = ~busy;
  assign sdo_oe     = ~rd;
endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk #(
  parameter int RES_BITS = 14,
  parameter int OUT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                convst,
  input logic                samp_valid,
  input logic                samp_ready,
  input logic [RES_BITS-1:0] samp_data,
  input logic                sdo,
  input logic                busy_n,
  input logic [2:0]          pos_ch,
  input logic [2:0]          neg_ch,
  input logic                neg_is_com,
  input logic                uni,
  input logic                gain,
  input logic [OUT_W-1:0]    res_word
);
  localparam int PAD = OUT_W - RES_BITS;

  assert_start_from_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(convst));

  assert_end_by_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(samp_valid && samp_ready));

  assert_ready_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready |-> !busy_n);

  assert_route_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n)) |-> $stable({pos_ch, neg_ch, neg_is_com, uni, gain}));

  assert_msb_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (sdo == $past(samp_data[RES_BITS-1])));

  generate
    if (PAD > 0) begin : g_padchk
      assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_word[PAD-1:0] == '0);
    end
  endgenerate
endmodule

bind adc_serial_slave adc_serial_slave_chk #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .convst     (convst),
  .samp_valid (samp_valid),
  .samp_ready (samp_ready),
  .samp_data  (samp_data),
  .sdo        (sdo),
  .busy_n     (busy_n),
  .pos_ch     (pos_ch),
  .neg_ch     (neg_ch),
  .neg_is_com (neg_is_com),
  .uni        (uni),
  .gain       (gain),
  .res_word   (res_word)
);

// File: tb/sim_adc_serial_slave.sv
module sim_adc_serial_slave;
  localparam int RES  = 14;
  localparam int CONV = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convst = 1'b0, rd = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [RES-1:0] samp_data = '0;
  logic samp_valid = 1'b0;
  logic samp_ready, sdo, sdo_oe, busy_n, neg_is_com, uni, gain;
  logic [2:0] pos_ch, neg_ch;
  logic [1:0] pd_req;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_serial_slave #(.RES_BITS(RES), .OUT_W(16), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .convst(convst), .rd(rd), .sck(sck), .sdi(sdi),
    .samp_data(samp_data), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy_n(busy_n), .pos_ch(pos_ch), .neg_ch(neg_ch),
    .neg_is_com(neg_is_com), .uni(uni), .gain(gain), .pd_req(pd_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_route(input string req, input logic [2:0] p, input logic [2:0] n,
                             input logic c, input logic u, input logic g);
    logic [31:0] a, e;
    a = {23'd0, pos_ch, neg_ch, neg_is_com, uni, gain};
    e = {23'd0, p, n, c, u, g};
    check(a == e, req, a, e);
  endtask

  // One 16-bit frame: setup bits first, then ones after the eighth bit.
  task automatic xfer(input logic [7:0] cfg, output logic [15:0] got);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      got[15-k] = sdo;
      sdi = (k < 8) ? cfg[7-k] : 1'b1;
      sck = 1'b1;
      @(negedge clk);
      sck = 1'b0;
    end
    @(negedge clk);
    sdi = 1'b0;
  endtask

  task automatic do_conv(input logic [RES-1:0] d, input int delay, input bit tie_rd, output int dur);
    int c0, w;
    bit early, oe_bad;
    @(negedge clk);
    samp_data = d;
    samp_valid = (delay == 0);
    convst = 1'b1;
    if (tie_rd) rd = 1'b1;
    c0 = cyc; w = 0; early = 1'b0; oe_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (busy_n) break;
      if (tie_rd && sdo_oe) oe_bad = 1'b1;
      if (samp_ready) begin
        if (cyc - c0 < CONV) early = 1'b1;
        if (!samp_valid) begin
          if (w == delay) samp_valid = 1'b1; else w++;
        end
      end
    end
    dur = cyc - c0;
    check(!early, "R6 ready before time up", {31'd0, early}, 0);
    if (tie_rd) check(!oe_bad && !sdo_oe, "R11 oe off while rd high", {31'd0, sdo_oe}, 0);
    convst = 1'b0;
    samp_valid = 1'b0;
    samp_data = '1;
    if (tie_rd) rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(busy_n == 1'b1, "R1 busy_n", {31'd0, busy_n}, 1);
    check(samp_ready == 1'b0, "R1 samp_ready", {31'd0, samp_ready}, 0);
    check(sdo == 1'b0, "R1 sdo", {31'd0, sdo}, 0);
    check(sdo_oe == 1'b1, "R11 oe with rd low", {31'd0, sdo_oe}, 1);
    check_route("R1 decoded reset", 3'd0, 3'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_single();
    logic [15:0] got; int dur;
    xfer(8'hD8, got);
    check(got == 16'h0000, "R8 reset result", {16'd0, got}, 0);
    check_route("R3 held before start", 3'd0, 3'd1, 1'b0, 1'b0, 1'b0);
    do_conv(14'h2A5C, 0, 1'b0, dur);
    check(dur == CONV + 1, "R5 busy length", dur, CONV + 1);
    check_route("R4 single-ended ch3", 3'd3, 3'd0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_diff();
    logic [15:0] got; int dur;
    xfer(8'h64, got);
    check(got == {14'h2A5C, 2'b00}, "R8 R9 result word", {16'd0, got}, {16'd0, 14'h2A5C, 2'b00});
    do_conv(14'h1337, 6, 1'b0, dur);
    check(dur == CONV + 7, "R6 back-pressure extends busy", dur, CONV + 7);
    check_route("R4 R2 differential 5/4", 3'd5, 3'd4, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_restart();
    logic [15:0] got, junk; int c0, dur;
    xfer(8'hA0, got);
    check(got == {14'h1337, 2'b00}, "R8 second result", {16'd0, got}, {16'd0, 14'h1337, 2'b00});
    @(negedge clk);
    samp_data = 14'h0F0F; samp_valid = 1'b1; convst = 1'b1;
    c0 = cyc;
    repeat (5) @(negedge clk);
    convst = 1'b0;
    xfer(8'h00, junk);
    convst = 1'b1;
    while (!busy_n) @(negedge clk);
    dur = cyc - c0;
    check(dur == CONV + 1, "R7 restart ignored", dur, CONV + 1);
    check_route("R7 R2 route kept", 3'd4, 3'd0, 1'b1, 1'b0, 1'b0);
    convst = 1'b0; samp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_collide();
    logic [15:0] got; bit bad;
    xfer(8'h9C, got);
    check(got == {14'h0F0F, 2'b00}, "R8 third result", {16'd0, got}, {16'd0, 14'h0F0F, 2'b00});
    @(negedge clk);
    convst = 1'b1; samp_valid = 1'b0;
    @(negedge clk);
    convst = 1'b0;
    while (!samp_ready) @(negedge clk);
    samp_valid = 1'b1; samp_data = 14'h3FFF; convst = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
    check(busy_n == 1'b1, "R7 completes on collision", {31'd0, busy_n}, 1);
    bad = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (!busy_n) bad = 1'b1;
    end
    check(!bad, "R7 collision edge not a start", {31'd0, bad}, 0);
    check_route("R4 single ch2", 3'd2, 3'd0, 1'b1, 1'b1, 1'b1);
    check(sdo == 1'b1, "R8 msb of new result", {31'd0, sdo}, 1);
    convst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_partial();
    logic [15:0] got; int dur;
    repeat (3) begin
      @(negedge clk); sdi = 1'b1; sck = 1'b1;
      @(negedge clk); sck = 1'b0;
    end
    do_conv(14'h0001, 0, 1'b0, dur);
    check_route("R2 partial frame ignored", 3'd2, 3'd0, 1'b1, 1'b1, 1'b1);
    xfer(8'h3A, got);
    check(got == {14'h0001, 2'b00}, "R9 trailing zeros", {16'd0, got}, {16'd0, 14'h0001, 2'b00});
    do_conv(14'h2000, 0, 1'b0, dur);
    check_route("R10 frame restarts at first bit", 3'd6, 3'd7, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_rdmode();
    logic [15:0] got; int dur;
    do_conv(14'h1555, 0, 1'b1, dur);
    check(sdo_oe == 1'b1, "R11 oe back when pins low", {31'd0, sdo_oe}, 1);
    xfer(8'h00, got);
    check(got == {14'h1555, 2'b00}, "R8 result after rd mode", {16'd0, got}, {16'd0, 14'h1555, 2'b00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_diff();
    t_restart();
    t_collide();
    t_partial();
    t_rdmode();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule